// File: doc/BRIEF.md
# Write-Only Serial Register Slave with Deferred Commit

This block is a receive-only I2C slave that fills a bank of twenty 8-bit control registers. A host addresses the device and sends a register pointer byte. It then sends one or more data bytes. Each accepted data byte goes into a holding copy of its register, and the pointer steps forward after every byte. The registers seen by the rest of the chip change only when the host ends the transfer with a Stop that qualifies for a commit. On that Stop, every holding register is copied into the active bank in the same clock cycle.

The bus lines arrive as plain inputs that the system clock oversamples. The block answers by pulling SDA low during acknowledge clocks. It is robust to corrupted traffic. A Stop that arrives after a new transfer has been addressed and given a pointer, but before any data byte, is ignored. A commit that is still pending survives repeated Starts aimed at other devices. Register 0 holds a broadcast flag. When that flag is set, a write to register 1 is copied into registers 1 to 18, which are the channel registers.

Top module: `i2c_wr_regslave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 001110 followed by the strap input `addr_sel_i`. With the strap at 0 it answers 0x38, and with the strap at 1 it answers 0x3A. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: An address byte whose last bit (read/write) is 1 is not acknowledged, even when the seven address bits match.
- R3: Bytes are received MSB first, with each bit sampled when SCL rises. `sda_pull_o` is high only during the ninth (acknowledge) clock of an accepted byte. It rises after the eighth SCL fall and drops after the ninth SCL fall.
- R4: The byte after the address is the pointer, and only its low 5 bits are used. Each data byte writes the register the pointer selects, and the pointer then steps by one. A data byte aimed at pointer value 20 or above is acknowledged but stored nowhere.
- R5: Data bytes go only to holding registers. `regs_o` does not change before a Stop that commits.
- R6: A commit copies all holding registers to `regs_o` in one cycle. `update_o` is high for exactly that one cycle. A commit happens only on a Stop while data is pending and no new transfer is waiting for its first data byte.
- R7: A Stop that arrives after the pointer byte of a new transfer, but before that transfer's first data byte, commits nothing. Data already pending is kept, and a later complete transfer ending in a Stop commits both the old and the new bytes.
- R8: Pending data stays pending across a repeated Start to another device address. The Stop that ends that other transfer commits it.
- R9: When bit 0 of active register 0 is 1, a data byte written to register 1 is written into holding registers 1 through 18. When that bit is 0, a write to register 1 affects only register 1.
- R10: While `rst_n` is low at a clock edge, all holding and active registers are cleared, `sda_pull_o` is low and `update_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap for the lowest device address bit |
| sda_pull_o | output | 1 | High drives SDA low (acknowledge) |
| regs_o | output | 160 | Active registers; register n in bits [8n+7:8n] |
| update_o | output | 1 | One-cycle pulse when the active bank is loaded |

## Verification
Each bus line passes through two synchronizer flops. A Start, a Stop or an SCL edge is therefore acted on at the third clock edge after the line changes. The acknowledge pull appears three cycles after the eighth SCL fall. A commit's new `regs_o` values and its `update_o` pulse both appear three cycles after SDA rises for the Stop. The bench holds every bus phase for four cycles and samples the acknowledge in the middle of the high phase of the ninth clock. It checks registers and pulse counts six cycles after a Stop, so every result is sampled after it is due. Pulse counts are taken before the Stop to show that nothing was committed early.

// File: rtl/i2cw_pkg.sv
// Shared definitions for the write-only serial register slave.
// Assumes: byte-wide registers; the receive state encoding is private to the engine.
package i2cw_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA
    } rx_state_t;
endpackage

// File: rtl/i2cw_line_sync.sv
// Synchronizes SCL and SDA to clk and decodes SCL edges, Start and Stop.
// Assumes: bus phases last at least two clk cycles; STAGES >= 2.
module i2cw_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Shift both lines through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    // Edge and bus-condition decode from the synchronized samples.
    always_comb begin
        sda_o      = sda_s;
        scl_rise_o = scl_s && !scl_q;
        scl_fall_o = !scl_s && scl_q;
        start_o    = scl_s && scl_q && sda_q && !sda_s;
        stop_o     = scl_s && scl_q && !sda_q && sda_s;
    end
endmodule

// File: rtl/i2cw_byte_engine.sv
// Receives bytes MSB first, matches the address, drives the acknowledge
// and tracks the register pointer. Emits one-cycle write strobes.
// Assumes: events come from i2cw_line_sync; NREG <= 2**PTR_W.
module i2cw_byte_engine
    import i2cw_pkg::*;
#(
    parameter int unsigned NREG  = 20,
    parameter int unsigned PTR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [6:0]        dev_addr_i,
    output logic              ack_o,
    output logic              sub_ack_o,
    output logic              data_ack_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [3:0]       CNT_FULL = 4'd8;   // eight bits shifted in
    localparam logic [3:0]       CNT_ACK  = 4'd9;   // acknowledge driven, waiting for its rise
    localparam logic [3:0]       CNT_DONE = 4'd10;  // acknowledge clock high, waiting for its fall
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NREG - 1);
    localparam logic [PTR_W-1:0] PTR_MAX  = '1;

    rx_state_t         state_q;
    logic [3:0]        cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              ack_q;
    logic              addr_hit;
    logic              ack_rise;

    // Address match needs the write direction (last bit 0).
    assign addr_hit = (shift_q[7:1] == dev_addr_i) && !shift_q[0];
    // The acknowledge clock rises: the host has seen this byte accepted.
    assign ack_rise = (state_q != ST_IDLE) && scl_rise_i && (cnt_q == CNT_ACK)
                      && !start_i && !stop_i;

    // Strobes to the commit control and the register bank.
    always_comb begin
        ack_o      = ack_q;
        sub_ack_o  = ack_rise && (state_q == ST_SUB);
        data_ack_o = ack_rise && (state_q == ST_DATA);
        wr_en_o    = data_ack_o && (ptr_q <= LAST_PTR);
        wr_ptr_o   = ptr_q;
        wr_data_o  = shift_q;
    end

    // Frame sequencing: bit counting, acknowledge and byte actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            ptr_q   <= '0;
            ack_q   <= 1'b0;
        end else if (start_i) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
        end else if (stop_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
        end else if (state_q != ST_IDLE) begin
            if (scl_rise_i) begin
                if (cnt_q < CNT_FULL) begin
                    shift_q <= {shift_q[BYTE_W-2:0], sda_i};
                    cnt_q   <= cnt_q + 4'd1;
                end else if (cnt_q == CNT_ACK) begin
                    cnt_q <= CNT_DONE;
                    case (state_q)
                        ST_ADDR: state_q <= ST_SUB;
                        ST_SUB: begin
                            ptr_q   <= shift_q[PTR_W-1:0];
                            state_q <= ST_DATA;
                        end
                        ST_DATA: if (ptr_q != PTR_MAX) ptr_q <= ptr_q + 1'b1;
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end else if (scl_fall_i) begin
                if (cnt_q == CNT_FULL) begin
                    if ((state_q == ST_ADDR) && !addr_hit) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        ack_q <= 1'b1;
                        cnt_q <= CNT_ACK;
                    end
                end else if (cnt_q == CNT_DONE) begin
                    ack_q <= 1'b0;
                    cnt_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/i2cw_commit_ctl.sv
// Decides when a Stop commits: data must be pending and no newly
// addressed transfer may be waiting for its first data byte.
// Assumes: strobes are one-cycle and never coincide with stop_i.
module i2cw_commit_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic sub_ack_i,
    input  logic data_ack_i,
    input  logic wr_en_i,
    output logic load_o
);
    logic pend_q;
    logic lock_q;

    assign load_o = stop_i && pend_q && !lock_q;

    // Track uncommitted data and the wait for a first data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (load_o)       pend_q <= 1'b0;
            else if (wr_en_i) pend_q <= 1'b1;
            if (sub_ack_i)       lock_q <= 1'b1;
            else if (data_ack_i) lock_q <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cw_reg_bank.sv
// Holding and active register copies, with the broadcast write into the
// channel group and a one-cycle update pulse on load.
// Assumes: FIRST_CH + NCH <= NREG; QW_REG/QW_BIT select the broadcast flag.
module i2cw_reg_bank
    import i2cw_pkg::*;
#(
    parameter int unsigned NREG     = 20,
    parameter int unsigned NCH      = 18,
    parameter int unsigned FIRST_CH = 1,
    parameter int unsigned QW_REG   = 0,
    parameter int unsigned QW_BIT   = 0,
    parameter int unsigned PTR_W    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [PTR_W-1:0]       wr_ptr_i,
    input  logic [BYTE_W-1:0]      wr_data_i,
    input  logic                   load_i,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic                   update_o
);
    localparam logic [PTR_W-1:0] BCAST_PTR = PTR_W'(FIRST_CH);

    logic [NREG*BYTE_W-1:0] act_flat;
    logic                   bcast;
    logic                   upd_q;

    assign bcast    = wr_en_i && act_flat[QW_REG*BYTE_W + QW_BIT] && (wr_ptr_i == BCAST_PTR);
    assign regs_o   = act_flat;
    assign update_o = upd_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam bit IN_GROUP = (g >= FIRST_CH) && (g < FIRST_CH + NCH);
        logic [BYTE_W-1:0] hold_q;
        logic [BYTE_W-1:0] act_q;
        logic              hit;

        assign hit = (wr_en_i && (wr_ptr_i == PTR_W'(g))) || (bcast && IN_GROUP);
        assign act_flat[g*BYTE_W +: BYTE_W] = act_q;

        // Capture writes in the holding copy; load it into the active copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q <= '0;
                act_q  <= '0;
            end else begin
                if (hit)    hold_q <= wr_data_i;
                if (load_i) act_q  <= hold_q;
            end
        end
    end

    // Update pulse aligned with the new active values.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= load_i;
    end
endmodule

// File: rtl/i2c_wr_regslave.sv
// Top level: write-only serial register slave with deferred commit.
// Assumes: scl_i/sda_i are oversampled by clk; SDA is open-drain outside.
module i2c_wr_regslave #(
    parameter logic [6:0]  BASE_ADDR   = 7'b0011100,
    parameter int unsigned NREG        = 20,
    parameter int unsigned NCH         = 18,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic            addr_sel_i,
    output logic            sda_pull_o,
    output logic [NREG*8-1:0] regs_o,
    output logic            update_o
);
    localparam int unsigned PTR_W = 5;

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_evt;
    logic             stop_evt;
    logic             sub_ack;
    logic             data_ack;
    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [7:0]       wr_data;
    logic             load;
    logic [6:0]       dev_addr;

    assign dev_addr = {BASE_ADDR[6:1], addr_sel_i};

    i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_evt), .stop_o(stop_evt)
    );

    i2cw_byte_engine #(.NREG(NREG), .PTR_W(PTR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_s),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_evt), .stop_i(stop_evt), .dev_addr_i(dev_addr),
        .ack_o(sda_pull_o), .sub_ack_o(sub_ack), .data_ack_o(data_ack),
        .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .wr_data_o(wr_data)
    );

    i2cw_commit_ctl u_commit (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_evt),
        .sub_ack_i(sub_ack), .data_ack_i(data_ack), .wr_en_i(wr_en),
        .load_o(load)
    );

    i2cw_reg_bank #(.NREG(NREG), .NCH(NCH), .PTR_W(PTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr),
        .wr_data_i(wr_data), .load_i(load),
        .regs_o(regs_o), .update_o(update_o)
    );
endmodule

// File: rtl/i2c_wr_regslave_chk.sv
// Protocol checker for i2c_wr_regslave, attached with bind.
// Assumes: synchronous active-low reset held for at least two cycles.
module i2c_wr_regslave_chk #(
    parameter int unsigned NREG = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_fall,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_pull_o,
    input logic              update_o,
    input logic [NREG*8-1:0] regs_o
);
    // R5: the active bank moves only together with the update pulse.
    p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> $stable(regs_o));

    // R6: the update pulse lasts one cycle.
    p_update_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R6: a commit follows a Stop on the bus.
    p_update_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> $past(stop_evt));

    // R3: the acknowledge pull starts after an SCL fall.
    p_ack_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    // R3: the acknowledge pull ends on an SCL fall or a bus condition.
    p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> $past(scl_fall || start_evt || stop_evt));
endmodule

bind i2c_wr_regslave i2c_wr_regslave_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .sda_pull_o(sda_pull_o), .update_o(update_o),
    .regs_o(regs_o)
);

// File: tb/i2c_wr_regslave_tb_top.sv
// Self-checking bench: a table of single-register writes, then directed
// tests for addressing, holding, stray Stops, broadcast and reset.
module i2c_wr_regslave_tb_top;
    localparam int NREG = 20;
    localparam int Q    = 4;   // clk cycles per bus quarter phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_pull;
    logic sda_line;
    logic [NREG*8-1:0] regs;
    logic update;

    int n_chk = 0;
    int n_fail = 0;
    int upd_cnt = 0;
    int pull_in_data = 0;
    logic [7:0] exp_r [NREG];

    assign sda_line = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    i2c_wr_regslave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .regs_o(regs),
        .update_o(update)
    );

    // Count cycles with the update pulse high.
    always @(negedge clk) if (update === 1'b1) upd_cnt++;

    // Single-register writes: {pointer byte, data byte}.
    localparam logic [15:0] WR_VEC [6] = '{
        16'h03A5, 16'h0C3C, 16'h13FF, 16'hE281, 16'h1107, 16'h00F0
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int bad = -1;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && regs[i*8 +: 8] !== exp_r[i]) bad = i;
        n_chk++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s reg%0d actual=%02h expected=%02h", tag, bad, regs[bad*8 +: 8], exp_r[bad]);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(Q);
            if (sda_pull) pull_in_data++;
            wait_clk(Q);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        acked = sda_pull;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic wr1(input logic [7:0] abyte, input logic [7:0] sub,
                       input logic [7:0] d, output logic all_ack);
        logic a0, a1, a2;
        bus_start();
        send_byte(abyte, a0);
        send_byte(sub, a1);
        send_byte(d, a2);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    initial begin : main
        logic ak, ak2, ak3;
        int u0;
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        wait_clk(4);
        // R10: reset state
        chk_val("R10 pull at reset", {31'b0, sda_pull}, 32'd0);
        chk_val("R10 update at reset", {31'b0, update}, 32'd0);
        check_all("R10 regs at reset");
        rst_n = 1'b1;
        wait_clk(4);

        // R4/R6: table of single writes, each committed by its Stop
        for (int k = 0; k < 6; k++) begin
            u0 = upd_cnt;
            wr1(8'h38, WR_VEC[k][15:8], WR_VEC[k][7:0], ak);
            exp_r[WR_VEC[k][12:8]] = WR_VEC[k][7:0];
            chk_val("R3 ack on table write", {31'b0, ak}, 32'd1);
            check_all("R4 table write");
            chk_val("R6 one pulse per commit", upd_cnt - u0, 32'd1);
        end

        // R5: held until Stop
        u0 = upd_cnt;
        bus_start(); send_byte(8'h38, ak); send_byte(8'h08, ak); send_byte(8'h11, ak);
        wait_clk(20);
        check_all("R5 no change before Stop");
        chk_val("R5 no pulse before Stop", upd_cnt - u0, 32'd0);
        bus_stop();
        exp_r[8] = 8'h11;
        check_all("R6 commit on Stop");
        chk_val("R6 pulse on Stop", upd_cnt - u0, 32'd1);

        // R4: auto-increment, pointer past last register, pointer 20
        bus_start(); send_byte(8'h38, ak); send_byte(8'h05, ak);
        send_byte(8'h21, ak); send_byte(8'h22, ak); send_byte(8'h23, ak); bus_stop();
        exp_r[5] = 8'h21; exp_r[6] = 8'h22; exp_r[7] = 8'h23;
        check_all("R4 auto-increment");
        bus_start(); send_byte(8'h38, ak); send_byte(8'h13, ak);
        send_byte(8'h91, ak); send_byte(8'h92, ak2); bus_stop();
        exp_r[19] = 8'h91;
        chk_val("R4 ack beyond last register", {31'b0, ak2}, 32'd1);
        check_all("R4 discard beyond last register");
        u0 = upd_cnt;
        wr1(8'h38, 8'h14, 8'h55, ak);
        chk_val("R4 pointer 20 acknowledged", {31'b0, ak}, 32'd1);
        check_all("R4 pointer 20 discarded");
        chk_val("R4 no commit for discarded byte", upd_cnt - u0, 32'd0);

        // R1: address and strap
        bus_start(); send_byte(8'h3A, ak); bus_stop();
        chk_val("R1 other address no ack", {31'b0, ak}, 32'd0);
        addr_sel = 1'b1;
        wr1(8'h3A, 8'h09, 8'h99, ak);
        exp_r[9] = 8'h99;
        chk_val("R1 strapped address ack", {31'b0, ak}, 32'd1);
        check_all("R1 strapped address write");
        bus_start(); send_byte(8'h38, ak); bus_stop();
        chk_val("R1 base address rejected when strapped", {31'b0, ak}, 32'd0);
        addr_sel = 1'b0;

        // R2: read direction refused
        bus_start(); send_byte(8'h39, ak); bus_stop();
        chk_val("R2 read bit no ack", {31'b0, ak}, 32'd0);

        // R7: stray Stop after pointer byte of a new transfer
        u0 = upd_cnt;
        bus_start(); send_byte(8'h38, ak); send_byte(8'h03, ak); send_byte(8'h44, ak);
        bus_start(); send_byte(8'h38, ak); send_byte(8'h04, ak); bus_stop();
        check_all("R7 stray Stop ignored");
        chk_val("R7 no pulse on stray Stop", upd_cnt - u0, 32'd0);
        wr1(8'h38, 8'h04, 8'h45, ak);
        exp_r[3] = 8'h44; exp_r[4] = 8'h45;
        check_all("R7 old and new data commit together");
        chk_val("R7 single pulse", upd_cnt - u0, 32'd1);

        // R8: pending data across repeated Start to another device
        bus_start(); send_byte(8'h38, ak); send_byte(8'h0A, ak); send_byte(8'h6B, ak);
        bus_start(); send_byte(8'hA0, ak3); bus_stop();
        exp_r[10] = 8'h6B;
        chk_val("R8 foreign address not acked", {31'b0, ak3}, 32'd0);
        check_all("R8 commit on foreign Stop");

        // R9: broadcast to channel registers
        wr1(8'h38, 8'h00, 8'h01, ak);
        exp_r[0] = 8'h01;
        wr1(8'h38, 8'h01, 8'h5A, ak);
        for (int i = 1; i <= 18; i++) exp_r[i] = 8'h5A;
        check_all("R9 broadcast write");
        wr1(8'h38, 8'h00, 8'h00, ak);
        exp_r[0] = 8'h00;
        wr1(8'h38, 8'h01, 8'h77, ak);
        exp_r[1] = 8'h77;
        check_all("R9 no broadcast when flag clear");

        // R3: no pull during data bits
        chk_val("R3 pull only in acknowledge clock", pull_in_data, 32'd0);

        // R10: reset mid-run
        rst_n = 1'b0; wait_clk(4);
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        check_all("R10 registers cleared");
        chk_val("R10 pull cleared", {31'b0, sda_pull}, 32'd0);
        rst_n = 1'b1; wait_clk(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule